// File: doc/BRIEF.md
# Write-Through Invalidate Snooping Cache

This block is a direct-mapped, write-through cache for a single processor that shares an atomic bus with other agents. Each line holds one data word, a tag and a single coherence bit (Valid or Invalid). A read that hits is served from the local array with no bus traffic. A read that misses fetches the word over the bus and installs it. Every write goes out on the bus. A write that hits also refreshes the local copy; a write that misses leaves the cache untouched.

The cache watches every transaction on the bus. A write by any other agent to a word it holds makes that line Invalid, so the next local read fetches the new value. The processor holds one request at a time and waits for a one-cycle ready pulse. The bus side raises a request, waits for a grant, and drives address, command and data only while granted. Completion is signalled by a done strobe that also carries the read data.

The controller has four states. `ST_IDLE` waits for a processor request. A read hit goes straight to `ST_RESP`. A miss or any write goes to `ST_REQ`. `ST_REQ` holds the bus request and moves to `ST_XFER` on grant. `ST_XFER` waits for the done strobe and then moves to `ST_RESP`, filling the line on a read or refreshing it on a write hit. `ST_RESP` raises ready for one cycle and returns to `ST_IDLE`.

Top module: `wt_snoop_cache`

## Requirements
- R1: Reset clears every valid bit and leaves `cpu_ready` and `bus_req` low, so the first read of any address after reset is a miss.
- R2: A read miss issues one bus transaction with `bus_cmd` = 0 (read) at the requested address. It installs the word from `bus_rdata` and returns it on `cpu_rdata` with `cpu_ready` in the cycle after `bus_done`. A miss to an index held under another tag replaces that line.
- R3: A read hit raises `cpu_ready` in the cycle after the request is first sampled, returns the stored word, and raises no bus request.
- R4: Every write, hit or miss, issues one bus transaction with `bus_cmd` = 1 (write), carrying `cpu_addr` and `cpu_wdata`. It completes with `cpu_ready` in the cycle after `bus_done`.
- R5: A write miss does not allocate, so a following read of that address is a miss.
- R6: A write hit refreshes the local word and the line stays Valid, so a following read hits and returns the written value.
- R7: A snooped transaction with `snoop_cmd` = 1 (write), `snoop_own` = 0 and an address matching a Valid line makes that line Invalid.
- R8: A snooped read, a snooped write flagged `snoop_own` = 1, or a snooped write whose tag differs from the stored tag leaves the line Valid.
- R9: When an invalidating snoop and a processor lookup of the same index fall in the same cycle, the invalidation wins and the lookup is a miss.
- R10: Once raised, `bus_req` stays high until `bus_gnt` arrives. While `bus_gnt` is low, `bus_addr`, `bus_cmd` and `bus_wdata` are all zero.
- R11: `cpu_ready` is high for exactly one cycle per request. The index is `cpu_addr[INDEX_W-1:0]` and the tag is the remaining upper bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` on reads |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| bus_cmd | output | 1 | 0 = read, 1 = write, driven while granted |
| bus_addr | output | ADDR_W | Address, driven while granted |
| bus_wdata | output | DATA_W | Write data, driven while granted |
| bus_rdata | input | DATA_W | Read data, valid with `bus_done` |
| bus_done | input | 1 | Transaction complete |
| snoop_valid | input | 1 | A bus transaction is visible this cycle |
| snoop_cmd | input | 1 | 0 = read, 1 = write |
| snoop_addr | input | ADDR_W | Address of the observed transaction |
| snoop_own | input | 1 | Observed transaction was issued by this cache |

## Verification
A read hit is due one cycle after the request is first sampled: the bench raises the request just after a falling edge and expects `cpu_ready` at the next falling edge. A miss or write is due one cycle after `bus_done`. The bench model grants two cycles after the request and raises done one cycle after the grant, so these accesses end at the fourth falling edge. An invalidation takes effect at the edge where the snoop is sampled. The bench therefore samples the follow-up read, or a same-cycle lookup, in the next cycle. It then counts bus transactions to tell hit from miss. All observation takes place just after a falling edge, while the design's outputs are settled.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_RESP
    } wtc_state_e;

    localparam logic CMD_RD = 1'b0;
    localparam logic CMD_WR = 1'b1;
endpackage

// File: rtl/wtc_tag_store.sv
module wtc_tag_store #(
    parameter int INDEX_W = 4,
    parameter int TAG_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0]   lk_tag,
    output logic               lk_hit,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic               kill_en,
    input  logic [INDEX_W-1:0] kill_idx,
    input  logic [TAG_W-1:0]   kill_tag
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];
    logic             kill_match;
    logic             raw_hit;

    // an invalidating snoop only acts when it names the stored tag
    assign kill_match = kill_en && valid_q[kill_idx] && (tag_q[kill_idx] == kill_tag);
    assign raw_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
    // snoop wins over a same-cycle lookup of that index (R9)
    assign lk_hit     = raw_hit && !(kill_match && (kill_idx == lk_idx));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (fill_en) begin
                valid_q[fill_idx] <= 1'b1;
            end
            if (kill_match) begin
                valid_q[kill_idx] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_q[fill_idx] <= fill_tag;
        end
    end
endmodule

// File: rtl/wtc_data_store.sv
module wtc_data_store #(
    parameter int INDEX_W = 4,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int LINES = 1 << INDEX_W;

    logic [DATA_W-1:0] mem_q [LINES];

    assign rd_data = mem_q[rd_idx];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
    import wtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req,
    input  logic cpu_we,
    input  logic lk_hit,
    input  logic bus_gnt,
    input  logic bus_done,
    output logic cpu_ready,
    output logic bus_req,
    output logic take_hit,
    output logic fill_en,
    output logic wupd_en
);
    wtc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    state_d = (!cpu_we && lk_hit) ? ST_RESP : ST_REQ;
                end
            end
            ST_REQ:  if (bus_gnt)  state_d = ST_XFER;
            ST_XFER: if (bus_done) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready = 1'b0;
        bus_req   = 1'b0;
        take_hit  = 1'b0;
        fill_en   = 1'b0;
        wupd_en   = 1'b0;
        unique case (state_q)
            ST_IDLE: take_hit = cpu_req && !cpu_we && lk_hit;
            ST_REQ:  bus_req  = 1'b1;
            ST_XFER: begin
                bus_req = 1'b1;
                fill_en = bus_done && !cpu_we;
                wupd_en = bus_done && cpu_we && lk_hit;
            end
            ST_RESP: cpu_ready = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_done,
    input  logic              snoop_valid,
    input  logic              snoop_cmd,
    input  logic [ADDR_W-1:0] snoop_addr,
    input  logic              snoop_own
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] cpu_idx, snp_idx;
    logic [TAG_W-1:0]   cpu_tag, snp_tag;
    logic               lk_hit, take_hit, fill_en, wupd_en, kill_en, granted;
    logic [DATA_W-1:0]  arr_rdata;
    logic [DATA_W-1:0]  rdata_q;

    assign cpu_idx = cpu_addr[INDEX_W-1:0];
    assign cpu_tag = cpu_addr[ADDR_W-1:INDEX_W];
    assign snp_idx = snoop_addr[INDEX_W-1:0];
    assign snp_tag = snoop_addr[ADDR_W-1:INDEX_W];
    assign kill_en = snoop_valid && (snoop_cmd == CMD_WR) && !snoop_own;

    wtc_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .lk_hit    (lk_hit),
        .bus_gnt   (bus_gnt),
        .bus_done  (bus_done),
        .cpu_ready (cpu_ready),
        .bus_req   (bus_req),
        .take_hit  (take_hit),
        .fill_en   (fill_en),
        .wupd_en   (wupd_en)
    );

    wtc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) i_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_idx   (cpu_idx),
        .lk_tag   (cpu_tag),
        .lk_hit   (lk_hit),
        .fill_en  (fill_en),
        .fill_idx (cpu_idx),
        .fill_tag (cpu_tag),
        .kill_en  (kill_en),
        .kill_idx (snp_idx),
        .kill_tag (snp_tag)
    );

    wtc_data_store #(.INDEX_W(INDEX_W), .DATA_W(DATA_W)) i_data (
        .clk     (clk),
        .wr_en   (fill_en || wupd_en),
        .wr_idx  (cpu_idx),
        .wr_data (fill_en ? bus_rdata : cpu_wdata),
        .rd_idx  (cpu_idx),
        .rd_data (arr_rdata)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (take_hit) begin
            rdata_q <= arr_rdata;
        end else if (fill_en) begin
            rdata_q <= bus_rdata;
        end
    end

    assign cpu_rdata = rdata_q;
    assign granted   = bus_req && bus_gnt;
    assign bus_cmd   = granted ? cpu_we : CMD_RD;
    assign bus_addr  = granted ? cpu_addr : '0;
    assign bus_wdata = (granted && cpu_we) ? cpu_wdata : '0;
endmodule

// File: rtl/wtc_checks.sv
module wtc_checks #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic              bus_done,
    input logic              bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    // R10: request held until grant
    a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_gnt |=> bus_req);

    // R10: bus lines quiet without grant
    a_r10_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_gnt |-> (bus_addr == '0 && bus_wdata == '0 && bus_cmd == 1'b0));

    // R11: ready is a single-cycle pulse
    a_r11_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    // R4: command on the bus follows the access kind
    a_r4_write_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_gnt |-> bus_cmd == cpu_we);

    // R4: a write only completes after a bus transaction
    a_r4_write_via_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && cpu_we |-> $past(bus_done));

    // R3: a read finishing without bus completion used no bus request
    a_r3_hit_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready && !cpu_we && !$past(bus_done) |-> !$past(bus_req));
endmodule

bind wt_snoop_cache wtc_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_wtc_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_we    (cpu_we),
    .cpu_ready (cpu_ready),
    .bus_req   (bus_req),
    .bus_gnt   (bus_gnt),
    .bus_done  (bus_done),
    .bus_cmd   (bus_cmd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/test_wt_snoop_cache.sv
module test_wt_snoop_cache;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req, bus_cmd;
    logic          bus_gnt = 1'b0, bus_done = 1'b0;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          snoop_valid = 1'b0, snoop_cmd = 1'b0, snoop_own = 1'b0;
    logic [AW-1:0] snoop_addr = '0;

    int n_checks = 0, n_fails = 0, txn = 0, gcnt = 0, quiet_bad = 0;
    logic          last_cmd;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_wdata;
    bit            done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wt_snoop_cache i_wt_snoop_cache (.*);

    function automatic logic [DW-1:0] memfn(input logic [AW-1:0] a);
        return {a, ~a} ^ 32'h5A0F_3C11;
    endfunction

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus model: grant two cycles after request, done one cycle after grant
    initial begin
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                bus_gnt = 0; bus_done = 0; gcnt = 0;
            end else if (bus_done) begin
                bus_done = 0; bus_gnt = 0;
            end else if (bus_gnt) begin
                bus_done   = 1;
                bus_rdata  = memfn(bus_addr);
                last_cmd   = bus_cmd;
                last_addr  = bus_addr;
                last_wdata = bus_wdata;
                txn++;
            end else if (bus_req) begin
                gcnt++;
                if (gcnt >= 2) begin bus_gnt = 1; gcnt = 0; end
            end
        end
    end

    task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input bit snp, input bit s_cmd, input logic [AW-1:0] s_addr, input bit s_own,
                          output logic [DW-1:0] rd, output int cycles, output int ntx);
        int t0 = txn;
        bit pulse_ok = 1;
        @(negedge clk); #1;
        cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        if (snp) begin snoop_valid = 1; snoop_cmd = s_cmd; snoop_addr = s_addr; snoop_own = s_own; end
        cycles = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk); #1;
            snoop_valid = 0;
            cycles++;
            if (!bus_gnt && (bus_addr != 0 || bus_wdata != 0)) quiet_bad++;
            if (cpu_ready) break;
        end
        rd = cpu_rdata;
        check(cpu_ready == 1'b1, "R11 ready seen", 32'(cpu_ready), 1);
        cpu_req = 0;
        @(negedge clk); #1;
        if (cpu_ready) pulse_ok = 0;
        check(pulse_ok, "R11 single pulse", 32'(cpu_ready), 0);
        ntx = txn - t0;
    endtask

    task automatic snoop(input bit s_cmd, input logic [AW-1:0] s_addr, input bit s_own);
        @(negedge clk); #1;
        snoop_valid = 1; snoop_cmd = s_cmd; snoop_addr = s_addr; snoop_own = s_own;
        @(negedge clk); #1;
        snoop_valid = 0;
    endtask

    localparam logic [AW-1:0] A  = 16'h1235;
    localparam logic [AW-1:0] A2 = 16'h4445;
    localparam logic [AW-1:0] B  = 16'h20A7;

    logic [DW-1:0] rd;
    int cyc, ntx;

    task automatic t_reset_and_miss();
        check(cpu_ready == 0 && bus_req == 0, "R1 reset outputs", {30'b0, cpu_ready, bus_req}, 0);
        access(0, A, 0, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 1, "R1 first read misses", ntx, 1);
        check(last_cmd == 1'b0 && last_addr == A, "R2 bus read addr", {15'b0, last_cmd, last_addr}, {16'b0, A});
        check(rd == memfn(A), "R2 fill data", rd, memfn(A));
        check(cyc == 4, "R2 ready after done", cyc, 4);
    endtask

    task automatic t_read_hit();
        access(0, A, 0, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 0, "R3 hit no bus", ntx, 0);
        check(cyc == 1, "R3 hit latency", cyc, 1);
        check(rd == memfn(A), "R3 hit data", rd, memfn(A));
    endtask

    task automatic t_write_miss();
        access(1, B, 32'hCAFE_0001, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 1 && last_cmd == 1'b1, "R4 write on bus", {31'b0, last_cmd}, 1);
        check(last_addr == B && last_wdata == 32'hCAFE_0001, "R4 write addr/data", last_wdata, 32'hCAFE_0001);
        check(cyc == 4, "R4 write completes after done", cyc, 4);
        access(0, B, 0, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 1, "R5 no allocate on write miss", ntx, 1);
    endtask

    task automatic t_write_hit();
        access(1, A, 32'hBEEF_0042, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 1 && last_wdata == 32'hBEEF_0042, "R4 write hit still on bus", last_wdata, 32'hBEEF_0042);
        access(0, A, 0, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 0, "R6 stays valid after write hit", ntx, 0);
        check(rd == 32'hBEEF_0042, "R6 local copy updated", rd, 32'hBEEF_0042);
    endtask

    task automatic t_snoop_inval();
        snoop(1, A, 0);
        access(0, A, 0, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 1, "R7 snooped write invalidates", ntx, 1);
        check(rd == memfn(A), "R7 refetched data", rd, memfn(A));
    endtask

    task automatic t_snoop_ignored();
        snoop(0, A, 0);
        snoop(1, A, 1);
        snoop(1, A2, 0);
        access(0, A, 0, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 0, "R8 harmless snoops keep line", ntx, 0);
    endtask

    task automatic t_snoop_priority();
        access(0, A, 0, 1, 1, A, 0, rd, cyc, ntx);
        check(ntx == 1, "R9 snoop beats same-cycle lookup", ntx, 1);
    endtask

    task automatic t_conflict();
        access(0, A2, 0, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 1 && rd == memfn(A2), "R2 conflict miss fill", rd, memfn(A2));
        access(0, A, 0, 0, 0, 0, 0, rd, cyc, ntx);
        check(ntx == 1, "R2 evicted line misses", ntx, 1);
        check(quiet_bad == 0, "R10 bus quiet without grant", quiet_bad, 0);
    endtask

    task automatic report();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        t_reset_and_miss();
        t_read_hit();
        t_write_miss();
        t_write_hit();
        t_snoop_inval();
        t_snoop_ignored();
        t_snoop_priority();
        t_conflict();
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        report();
    end
endmodule